// File: doc/BRIEF.md
# DSD Bitstream Validity Monitor

The monitor sits on a one-bit Direct Stream Digital audio path and judges, bit by bit, whether the stream still looks like real modulated audio. Each bit arrives with a valid strobe on the bit clock. Two separate checks run side by side. A run check looks for a stream that is stuck at one level. A density check looks for a stream whose mix of ones and zeros over a 28-bit sliding window is too lopsided. A stuck stream raises a mute request toward the converter. A lopsided stream raises a softer attenuate request.

Each check has its own enable. A check says nothing until it has seen a full window of valid bits since reset or since it was last enabled. Both flags are levels. They are recomputed on every accepted bit and drop as soon as the condition stops holding. A direct-conversion control tells the monitor that the stream goes straight to the converter. In that mode both requests are held low while the detectors keep tracking the stream. In every mode the data bit is passed through with one register of delay.

Top module: `dsd_stream_monitor`

## Requirements
- R1: With `static_en` high, `mute_req` is high after the clock edge that accepts the 28th consecutive equal valid bit counted since reset or since `static_en` rose, and it stays high while further equal bits arrive.
- R2: After 27 equal bits `mute_req` is still low. A valid bit that differs from its predecessor restarts the run at length one.
- R3: While `static_en` is low, `mute_req` is low. After `static_en` rises, a new run of 28 equal valid bits is needed before it can rise.
- R4: With `density_en` high, `atten_req` is high when more than 24 of the last 28 valid bits are ones. With exactly 24 ones it is low.
- R5: With `density_en` high, `atten_req` is high when fewer than 4 of the last 28 valid bits are ones. With exactly 4 ones it is low.
- R6: `atten_req` stays low until 28 valid bits have been accepted since reset or since `density_en` rose. While `density_en` is low it stays low.
- R7: Both flags are levels. Each one falls on the edge that accepts the first valid bit for which its condition no longer holds.
- R8: While `direct_mode` is high, `mute_req` and `atten_req` are low. When it goes low they show the detectors' current result at once, because detection continues during direct mode.
- R9: `bit_out` takes the value of `bit_in` on the clock edge where `bit_valid` is high, in every mode, and it holds that value while `bit_valid` is low.
- R10: Clock edges with `bit_valid` low change neither flag nor any detector state.
- R11: After reset, `mute_req`, `atten_req` and `bit_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DSD bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | High when `bit_in` carries a stream bit this cycle |
| bit_in | input | 1 | DSD stream bit |
| static_en | input | 1 | Enables the stuck-stream run check |
| density_en | input | 1 | Enables the sliding-window density check |
| direct_mode | input | 1 | Direct conversion selected; requests forced low |
| mute_req | output | 1 | Stuck-stream fault, mute request |
| atten_req | output | 1 | Lopsided-stream fault, attenuate request |
| bit_out | output | 1 | Stream bit delayed by one register |

## Verification
Runs of 27 and 28 equal bits at both levels separate the exact run threshold from an off-by-one, and a single flipped bit shows whether the run restarts. Repeating 28-bit patterns with 25 and 24 ones, and with 3 and 4 ones, place the density window on both sides of each threshold. Long stretches with an enable held low, followed by enabling in the middle of a stream, show whether the fill gating restarts. Toggling direct mode and idle gaps while a fault is active show that the requests are masked but not forgotten, and that idle cycles leave everything unchanged.

// File: rtl/dsd_mon_pkg.sv
package dsd_mon_pkg;

  localparam int unsigned DSD_WIN = 28;
  localparam int unsigned DSD_HI  = 24;

  function automatic int unsigned sat_next(int unsigned v, int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  function automatic logic density_bad(int unsigned ones, int unsigned win,
                                       int unsigned hi);
    return (ones > hi) || (ones < (win - hi));
  endfunction

endpackage

// File: rtl/dsd_run_detector.sv
module dsd_run_detector
  import dsd_mon_pkg::*;
#(
  parameter int unsigned WIN = DSD_WIN,
  localparam int unsigned CW = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          valid,
  input  logic          din,
  output logic [CW-1:0] run_len,
  output logic          hit
);

  logic last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_len <= '0;
      last_q  <= 1'b0;
    end else if (!en) begin
      run_len <= '0;
    end else if (valid) begin
      if (run_len == '0 || din != last_q)
        run_len <= CW'(1);
      else
        run_len <= CW'(sat_next(32'(run_len), WIN));
      last_q <= din;
    end
  end

  assign hit = en && (run_len == CW'(WIN));

endmodule

// File: rtl/dsd_density_window.sv
module dsd_density_window
  import dsd_mon_pkg::*;
#(
  parameter int unsigned WIN = DSD_WIN,
  parameter int unsigned HI  = DSD_HI,
  localparam int unsigned CW = $clog2(WIN + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           valid,
  input  logic           din,
  output logic [WIN-1:0] win_bits,
  output logic [CW-1:0]  ones_cnt,
  output logic [CW-1:0]  fill_cnt,
  output logic           hit
);

  logic          leaving;
  logic [CW-1:0] cnt_next;

  assign leaving  = win_bits[WIN-1];
  assign cnt_next = ones_cnt + CW'(din) - CW'(leaving);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_bits <= '0;
      ones_cnt <= '0;
    end else if (valid) begin
      win_bits <= {win_bits[WIN-2:0], din};
      ones_cnt <= cnt_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en)
      fill_cnt <= '0;
    else if (valid)
      fill_cnt <= CW'(sat_next(32'(fill_cnt), WIN));
  end

  assign hit = en && (fill_cnt == CW'(WIN)) &&
               density_bad(32'(ones_cnt), WIN, HI);

endmodule

// File: rtl/dsd_out_stage.sv
module dsd_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic din,
  input  logic direct,
  input  logic static_hit,
  input  logic dense_hit,
  output logic mute,
  output logic atten,
  output logic dout
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      dout <= 1'b0;
    else if (valid)
      dout <= din;
  end

  assign mute  = static_hit && !direct;
  assign atten = dense_hit  && !direct;

endmodule

// File: rtl/dsd_stream_monitor.sv
module dsd_stream_monitor
  import dsd_mon_pkg::*;
#(
  parameter int unsigned WIN = DSD_WIN,
  parameter int unsigned HI  = DSD_HI,
  localparam int unsigned CW = $clog2(WIN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_in,
  input  logic static_en,
  input  logic density_en,
  input  logic direct_mode,
  output logic mute_req,
  output logic atten_req,
  output logic bit_out
);

  logic [CW-1:0]  run_len;
  logic [CW-1:0]  ones_cnt;
  logic [CW-1:0]  fill_cnt;
  logic [WIN-1:0] win_bits;
  logic           static_hit;
  logic           dense_hit;

  dsd_run_detector #(.WIN(WIN)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (static_en),
    .valid   (bit_valid),
    .din     (bit_in),
    .run_len (run_len),
    .hit     (static_hit)
  );

  dsd_density_window #(.WIN(WIN), .HI(HI)) u_dens (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (density_en),
    .valid    (bit_valid),
    .din      (bit_in),
    .win_bits (win_bits),
    .ones_cnt (ones_cnt),
    .fill_cnt (fill_cnt),
    .hit      (dense_hit)
  );

  dsd_out_stage u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid      (bit_valid),
    .din        (bit_in),
    .direct     (direct_mode),
    .static_hit (static_hit),
    .dense_hit  (dense_hit),
    .mute       (mute_req),
    .atten      (atten_req),
    .dout       (bit_out)
  );

endmodule

// File: rtl/dsd_stream_monitor_chk.sv
module dsd_stream_monitor_chk #(
  parameter int unsigned WIN = 28,
  localparam int unsigned CW = $clog2(WIN + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bit_valid,
  input logic           bit_in,
  input logic           static_en,
  input logic           density_en,
  input logic           direct_mode,
  input logic           mute_req,
  input logic           atten_req,
  input logic           bit_out,
  input logic [CW-1:0]  run_len,
  input logic [CW-1:0]  ones_cnt,
  input logic [CW-1:0]  fill_cnt,
  input logic [WIN-1:0] win_bits
);

  // R1: a mute request needs a full-length run
  assert_mute_needs_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mute_req |-> (run_len == CW'(WIN)));

  // R3: disabled run check never mutes
  assert_static_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !static_en |-> !mute_req);

  // R4: running count agrees with the window contents
  assert_count_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(win_bits) == 32'(ones_cnt)));

  // R6: attenuate only with a filled window and the check enabled
  assert_atten_needs_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    atten_req |-> (fill_cnt == CW'(WIN)) && density_en);

  // R8: direct mode silences both requests
  assert_direct_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    direct_mode |-> !mute_req && !atten_req);

  // R9: one-register pass-through
  assert_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> (bit_out == $past(bit_in)));

  // R10: idle edges leave the window unchanged
  assert_idle_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(win_bits) && $stable(ones_cnt));

endmodule

bind dsd_stream_monitor dsd_stream_monitor_chk #(.WIN(WIN)) u_chk (.*);

// File: tb/dsd_stream_monitor_test.sv
`timescale 1ns/1ps
module dsd_stream_monitor_test;

  localparam int WIN = 28;
  localparam int HI  = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic static_en = 1'b1;
  logic density_en = 1'b0;
  logic direct_mode = 1'b0;
  logic mute_req, atten_req, bit_out;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  // bench-side history of accepted bits
  bit hist [0:8191];
  int nb = 0;
  int s_base = 0;
  int d_base = 0;
  logic last_out = 1'b0;

  always #2 clk = ~clk;

  dsd_stream_monitor uut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .static_en(static_en), .density_en(density_en), .direct_mode(direct_mode),
    .mute_req(mute_req), .atten_req(atten_req), .bit_out(bit_out)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b (bit %0d)", req, what, act, exp, nb);
    end
  endtask

  function automatic logic exp_static();
    if (!static_en || (nb - s_base) < WIN) return 1'b0;
    for (int i = nb - WIN + 1; i < nb; i++)
      if (hist[i] != hist[nb - WIN]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic exp_dense();
    int ones = 0;
    if (!density_en || (nb - d_base) < WIN) return 1'b0;
    for (int i = nb - WIN; i < nb; i++) ones += int'(hist[i]);
    return (ones > HI) || (ones < WIN - HI);
  endfunction

  task automatic check_flags(string tag);
    chk(tag, "mute_req", mute_req, exp_static() && !direct_mode);
    chk(tag, "atten_req", atten_req, exp_dense() && !direct_mode);
  endtask

  // drive one valid bit, then check at the following falling edge
  task automatic send(logic b, string tag);
    @(negedge clk);
    bit_in = b;
    bit_valid = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0;
    hist[nb] = b;
    nb++;
    last_out = b;
    chk("R9", "bit_out", bit_out, b);
    check_flags(tag);
  endtask

  task automatic set_cfg(logic s_en, logic d_en);
    @(negedge clk);
    if (s_en && !static_en) s_base = nb;
    if (d_en && !density_en) d_base = nb;
    static_en = s_en;
    density_en = d_en;
    @(negedge clk);
    check_flags("R3/R6 config");
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bit_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nb = 0; s_base = 0; d_base = 0; last_out = 1'b0;
    for (int i = 0; i < WIN; i++) hist[i] = 1'b0;
  endtask

  // send a 28-bit pattern several times
  task automatic send_pattern(logic [WIN-1:0] pat, int reps, string tag);
    for (int r = 0; r < reps; r++)
      for (int i = 0; i < WIN; i++) send(pat[i], tag);
  endtask

  task automatic t_reset();
    static_en = 1'b1; density_en = 1'b0; direct_mode = 1'b0;
    do_reset();
    @(negedge clk);
    chk("R11", "mute_req", mute_req, 1'b0);
    chk("R11", "atten_req", atten_req, 1'b0);
    chk("R11", "bit_out", bit_out, 1'b0);
  endtask

  task automatic t_static_run();
    set_cfg(1'b1, 1'b0);
    for (int i = 0; i < 27; i++) send(1'b1, "R2 27 ones");
    chk("R2", "mute after 27", mute_req, 1'b0);
    send(1'b1, "R1 28th one");
    chk("R1", "mute after 28", mute_req, 1'b1);
    for (int i = 0; i < 5; i++) send(1'b1, "R1 hold");
    send(1'b0, "R7 break");
    chk("R7", "mute cleared", mute_req, 1'b0);
    for (int i = 0; i < 26; i++) send(1'b0, "R2 zeros");
    chk("R2", "mute after 27 zeros", mute_req, 1'b0);
    send(1'b0, "R1 28th zero");
    chk("R1", "mute after 28 zeros", mute_req, 1'b1);
  endtask

  task automatic t_static_disable();
    set_cfg(1'b0, 1'b0);
    for (int i = 0; i < 40; i++) send(1'b1, "R3 disabled");
    chk("R3", "mute while off", mute_req, 1'b0);
    set_cfg(1'b1, 1'b0);
    for (int i = 0; i < 27; i++) send(1'b1, "R3 re-enable");
    chk("R3", "mute 27 after enable", mute_req, 1'b0);
    send(1'b1, "R3 28 after enable");
    chk("R3", "mute 28 after enable", mute_req, 1'b1);
  endtask

  task automatic t_density_high();
    do_reset();
    static_en = 1'b0; s_base = 0;
    set_cfg(1'b0, 1'b1);
    // 25 ones: zeros at bits 3, 11, 20
    send_pattern(~((28'd1 << 3) | (28'd1 << 11) | (28'd1 << 20)), 2, "R4/R6 25 ones");
    chk("R4", "atten 25 ones", atten_req, 1'b1);
    // 24 ones: zeros at bits 2, 9, 16, 23
    send_pattern(~((28'd1 << 2) | (28'd1 << 9) | (28'd1 << 16) | (28'd1 << 23)), 2, "R4/R7 24 ones");
    chk("R4", "atten 24 ones", atten_req, 1'b0);
  endtask

  task automatic t_density_low();
    set_cfg(1'b0, 1'b0);
    send_pattern(28'h0000001, 1, "R6 disabled");
    chk("R6", "atten while off", atten_req, 1'b0);
    set_cfg(1'b0, 1'b1);
    // 3 ones
    send_pattern((28'd1 << 5) | (28'd1 << 14) | (28'd1 << 22), 2, "R5/R6 3 ones");
    chk("R5", "atten 3 ones", atten_req, 1'b1);
    // 4 ones
    send_pattern((28'd1 << 1) | (28'd1 << 8) | (28'd1 << 15) | (28'd1 << 24), 2, "R5/R7 4 ones");
    chk("R5", "atten 4 ones", atten_req, 1'b0);
  endtask

  task automatic t_direct();
    set_cfg(1'b1, 1'b1);
    for (int i = 0; i < 30; i++) send(1'b0, "R1 both faults");
    chk("R1", "mute before direct", mute_req, 1'b1);
    chk("R5", "atten before direct", atten_req, 1'b1);
    @(negedge clk);
    direct_mode = 1'b1;
    #1;
    chk("R8", "mute in direct", mute_req, 1'b0);
    chk("R8", "atten in direct", atten_req, 1'b0);
    send(1'b0, "R8 direct bit");
    send(1'b1, "R8 direct bit");
    send(1'b1, "R8 direct bit");
    for (int i = 0; i < 30; i++) send(1'b1, "R8 direct run");
    @(negedge clk);
    direct_mode = 1'b0;
    #1;
    chk("R8", "mute after direct", mute_req, 1'b1);
    chk("R8", "atten after direct", atten_req, 1'b1);
  endtask

  task automatic t_idle();
    logic m0, a0;
    @(negedge clk);
    m0 = mute_req; a0 = atten_req;
    @(negedge clk);
    bit_in = ~last_out;
    repeat (6) @(negedge clk);
    chk("R10", "mute idle", mute_req, m0);
    chk("R10", "atten idle", atten_req, a0);
    chk("R9", "bit_out held", bit_out, last_out);
    send(1'b1, "R10 after idle");
    chk("R10", "run kept across idle", mute_req, 1'b1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_static_run();
    t_static_disable();
    t_density_high();
    t_density_low();
    t_direct();
    t_idle();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule